// File: doc/BRIEF.md
# Control Channel Bit Serializer

The block produces a serial control line that carries one bit for every output stream and channel pair of a time-division switch. With the default sizing that is 8 streams of 32 channels, so each frame holds 256 control bits at the transmit bit rate. The flag for each bit comes from a per-channel flag array that is supplied on `flags_i`. That array holds the control-output flag of each output channel's control word. How the array is programmed is outside this block.

The line runs in lockstep with the transmit streams and leads them by one channel. During transmit channel `c`, the line carries the flags of channel `c+1` (modulo the channel count) for every stream. Within a channel period the stream index rises from 0 to 7 while the transmit bit index falls from 7 to 0. The flags of channel 0 are therefore sent in the last channel period of the previous frame. This lead gives external control circuitry one channel time to act before the matching transmit channel appears.

The output register moves only on a bit-boundary strobe. A frame-start strobe that coincides with a bit strobe restarts the sequence at slot 0. Before the first frame start the line stays low.

Top module: `ccs_serializer`

## Requirements
- R1: After reset, `ctl_o` is low and stays low on every bit strobe until the first bit strobe that has `frame_i` high.
- R2: `ctl_o` changes only in the clock cycle that follows a cycle with `bit_stb_i` high. In all other cycles it holds its value.
- R3: A bit strobe with `frame_i` high restarts the sequence at slot 0. From the next cycle, `ctl_o` equals the flag of stream 0, channel 1, which is `flags_i[1]`.
- R4: Slot `p` (0..255, counted from the frame start) lies in transmit channel `p/8` at transmit bit `7 - p%8`. It carries the flag of stream `p%8`, so within one channel period the streams are sent in the order 0 to 7.
- R5: The bit sent in slot `p` is the flag of channel `(p/8 + 1) mod 32`. The flag array is indexed as `flags_i[stream*32 + channel]`. A high flag gives a high bit and a low flag gives a low bit.
- R6: The last channel period of a frame (slots 248..255) carries the channel 0 flags of streams 0..7. Slot 255 carries `flags_i[224]`.
- R7: If no frame start arrives, the slot count wraps from 255 to 0 and the sequence repeats.
- R8: A frame start in the middle of a frame abandons the current position and restarts at slot 0.
- R9: The flag value used for a slot is the one present on `flags_i` in the strobe cycle that moves the line to that slot.
- R10: `frame_i` high without `bit_stb_i` has no effect on `ctl_o` or on the slot sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_stb_i | input | 1 | One-cycle bit-boundary strobe |
| frame_i | input | 1 | Frame start, honoured only together with `bit_stb_i` |
| flags_i | input | 256 | Control-output flags, index stream*32 + channel |
| ctl_o | output | 1 | Serial control output |

## Verification
The bench builds the block with its default sizing: 8 streams, 32 channels and a lead of one channel. At that size the whole 256-slot frame can be exercised several times within a short run. This covers the channel-0 wrap into the last channel period, the free-running wrap from slot 255 back to 0, and a restart from mid-frame. Bit strobes are spaced four clocks apart, which leaves idle cycles in which the bench checks that the line holds. The bench also changes the flags and pulses a frame start without a bit strobe during those idle cycles.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int unsigned CCS_STREAMS_DEF = 8;
  localparam int unsigned CCS_CHANS_DEF   = 32;
  localparam int unsigned CCS_LEAD_DEF    = 1;

  typedef enum logic [0:0] {
    CCS_WAIT = 1'b0,
    CCS_LIVE = 1'b1
  } ccs_state_e;
endpackage

// File: rtl/ccs_slot_counter.sv
module ccs_slot_counter #(
  parameter int unsigned SLOTS = 256,
  localparam int unsigned SLW  = $clog2(SLOTS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bit_stb_i,
  input  logic           frame_i,
  output logic [SLW-1:0] nxt_slot_o,
  output logic           load_o
);
  import ccs_pkg::*;

  localparam logic [SLW-1:0] LAST = SLW'(SLOTS - 1);

  ccs_state_e      state_q;
  logic [SLW-1:0]  slot_q;
  logic [SLW-1:0]  nxt_slot;

  always_comb begin
    if (frame_i)            nxt_slot = '0;
    else if (slot_q == LAST) nxt_slot = '0;
    else                     nxt_slot = slot_q + 1'b1;
  end

  // Advance on a bit strobe once aligned; a frame start aligns.
  assign load_o     = bit_stb_i && (frame_i || state_q == CCS_LIVE);
  assign nxt_slot_o = nxt_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CCS_WAIT;
      slot_q  <= '0;
    end else if (load_o) begin
      state_q <= CCS_LIVE;
      slot_q  <= nxt_slot;
    end
  end
endmodule

// File: rtl/ccs_flag_select.sv
module ccs_flag_select #(
  parameter int unsigned STREAMS = 8,
  parameter int unsigned CHANS   = 32,
  parameter int unsigned LEAD    = 1,
  localparam int unsigned SW     = $clog2(STREAMS),
  localparam int unsigned CW     = $clog2(CHANS),
  localparam int unsigned SLW    = SW + CW,
  localparam int unsigned NFLAGS = STREAMS * CHANS
) (
  input  logic [SLW-1:0]    slot_i,
  input  logic [NFLAGS-1:0] flags_i,
  output logic              flag_o
);
  localparam logic [CW-1:0] LEAD_W = CW'(LEAD % CHANS);

  logic [SW-1:0]  stream;
  logic [CW-1:0]  tx_chan;
  logic [CW-1:0]  chan;
  logic [SLW-1:0] idx;

  assign stream  = slot_i[SW-1:0];
  assign tx_chan = slot_i[SLW-1:SW];

  generate
    if (LEAD % CHANS == 0) begin : g_no_lead
      assign chan = tx_chan;
    end else begin : g_lead
      assign chan = tx_chan + LEAD_W; // wraps modulo CHANS
    end
  endgenerate

  assign idx    = {stream, chan};
  assign flag_o = flags_i[idx];
endmodule

// File: rtl/ccs_out_reg.sv
module ccs_out_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/ccs_serializer.sv
module ccs_serializer #(
  parameter int unsigned STREAMS = ccs_pkg::CCS_STREAMS_DEF,
  parameter int unsigned CHANS   = ccs_pkg::CCS_CHANS_DEF,
  parameter int unsigned LEAD    = ccs_pkg::CCS_LEAD_DEF,
  localparam int unsigned SLOTS  = STREAMS * CHANS,
  localparam int unsigned SLW    = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             frame_i,
  input  logic [SLOTS-1:0] flags_i,
  output logic             ctl_o
);
  logic [SLW-1:0] nxt_slot;
  logic           load;
  logic           flag;

  ccs_slot_counter #(.SLOTS(SLOTS)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_stb_i  (bit_stb_i),
    .frame_i    (frame_i),
    .nxt_slot_o (nxt_slot),
    .load_o     (load)
  );

  ccs_flag_select #(.STREAMS(STREAMS), .CHANS(CHANS), .LEAD(LEAD)) u_sel (
    .slot_i  (nxt_slot),
    .flags_i (flags_i),
    .flag_o  (flag)
  );

  ccs_out_reg u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .d_i    (flag),
    .q_o    (ctl_o)
  );
endmodule

// File: rtl/ccs_serializer_chk.sv
module ccs_serializer_chk #(
  parameter int unsigned STREAMS = 8,
  parameter int unsigned CHANS   = 32,
  parameter int unsigned LEAD    = 1,
  localparam int unsigned SLOTS  = STREAMS * CHANS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_stb_i,
  input logic             frame_i,
  input logic [SLOTS-1:0] flags_i,
  input logic             ctl_o
);
  int unsigned slot_q;
  logic        seen_q;
  int unsigned exp_slot;
  logic        exp_flag;

  always_comb begin
    exp_slot = (slot_q + 1) % SLOTS;
    exp_flag = flags_i[(exp_slot % STREAMS) * CHANS + ((exp_slot / STREAMS) + LEAD) % CHANS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= 0;
      seen_q <= 1'b0;
    end else if (bit_stb_i && frame_i) begin
      slot_q <= 0;
      seen_q <= 1'b1;
    end else if (bit_stb_i && seen_q) begin
      slot_q <= exp_slot;
    end
  end

  assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !ctl_o);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_i |=> $stable(ctl_o));

  assert_frame_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && frame_i) |=> ctl_o == $past(flags_i[LEAD % CHANS]));

  assert_sequence_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && !frame_i && seen_q) |=> ctl_o == $past(exp_flag));

  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && !frame_i && seen_q && slot_q == SLOTS - 2)
      |=> ctl_o == $past(flags_i[(STREAMS - 1) * CHANS + (CHANS - 1 + LEAD) % CHANS]));

  assert_no_frame_alone_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !bit_stb_i) |=> $stable(ctl_o));
endmodule

bind ccs_serializer ccs_serializer_chk #(.STREAMS(STREAMS), .CHANS(CHANS), .LEAD(LEAD)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_stb_i (bit_stb_i),
  .frame_i   (frame_i),
  .flags_i   (flags_i),
  .ctl_o     (ctl_o)
);

// File: tb/ccs_serializer_bench.sv
module ccs_serializer_bench;
  localparam int STREAMS = 8;
  localparam int CHANS   = 32;
  localparam int SLOTS   = STREAMS * CHANS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bit_stb = 1'b0;
  logic             frame = 1'b0;
  logic [SLOTS-1:0] flags = '0;
  logic             ctl;

  int n_chk = 0;
  int n_bad = 0;
  int slot  = 0;
  bit synced = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ccs_serializer u_ccs_serializer (
    .clk_i (clk), .rst_ni (rst_n), .bit_stb_i (bit_stb), .frame_i (frame),
    .flags_i (flags), .ctl_o (ctl)
  );

  function automatic logic exp_bit(int p, logic [SLOTS-1:0] f);
    int s = p % STREAMS;
    int c = (p / STREAMS + 1) % CHANS;
    return f[s * CHANS + c];
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s slot=%0d actual=%b expected=%b", req, slot, act, exp);
    end
  endtask

  task automatic rand_flags();
    for (int i = 0; i < SLOTS; i += 32) flags[i +: 32] = $urandom;
  endtask

  // one bit strobe, then idle cycles checking the hold behaviour
  task automatic do_bit(logic frm, string req);
    logic held;
    @(negedge clk);
    bit_stb = 1'b1;
    frame   = frm;
    @(negedge clk);
    bit_stb = 1'b0;
    frame   = 1'b0;
    if (frm) begin
      slot = 0;
      synced = 1'b1;
    end else if (synced) begin
      slot = (slot + 1) % SLOTS;
    end
    if (synced) check(req, ctl, exp_bit(slot, flags));
    else        check("R1", ctl, 1'b0);
    held = ctl;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R2", ctl, held);
    end
  endtask

  function automatic string tag_for(int p);
    if (p >= SLOTS - STREAMS) return "R6";
    return "R5";
  endfunction

  task automatic run_slots(int n);
    for (int i = 0; i < n; i++) begin
      int p = (slot + 1) % SLOTS;
      do_bit(1'b0, (p == 0) ? "R7" : tag_for(p));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    flags = '1;
    repeat (3) @(negedge clk);
    check("R1", ctl, 1'b0);
    rst_n = 1'b1;
    // R1: no frame yet, ones in flags must not reach the line
    for (int i = 0; i < 5; i++) do_bit(1'b0, "R1");

    // R3 with directed single-flag patterns
    flags = '0; flags[1] = 1'b1;
    do_bit(1'b1, "R3");
    flags = '0;
    do_bit(1'b1, "R3");

    // R4: stream order within one channel, single stream flag set
    flags = '0; flags[3 * CHANS + 1] = 1'b1;
    do_bit(1'b1, "R4");
    for (int i = 1; i < STREAMS; i++) do_bit(1'b0, "R4");

    // R6: only slot 255 flag (stream 7 channel 0 = index 224)
    flags = '0; flags[224] = 1'b1;
    do_bit(1'b1, "R3");
    run_slots(SLOTS - 1);
    check("R6", ctl, 1'b1);

    // random frames, flags refreshed at frame starts
    for (int f = 0; f < 3; f++) begin
      rand_flags();
      do_bit(1'b1, "R3");
      run_slots(SLOTS - 1);
    end

    // R7: free-running wrap without frame start
    rand_flags();
    run_slots(SLOTS + 20);

    // R8: restart mid-frame
    rand_flags();
    run_slots(80);
    do_bit(1'b1, "R8");
    run_slots(40);

    // R9: flags change during idle cycles, used by the next strobe
    for (int i = 0; i < 60; i++) begin
      rand_flags();
      run_slots(1);
    end

    // R10: frame without strobe is ignored
    for (int i = 0; i < 10; i++) begin
      logic held;
      @(negedge clk);
      frame = 1'b1;
      held = ctl;
      @(negedge clk);
      frame = 1'b0;
      check("R10", ctl, held);
      do_bit(1'b0, "R10");
    end

    // random mix
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 9) == 0) rand_flags();
      if ($urandom_range(0, 99) == 0) do_bit(1'b1, "R8");
      else run_slots(1);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule